// File: doc/BRIEF.md
# Protected Converter Register Bank

This block is the control register bank of a multi-port media-interface converter. It stores the routing-mode word, a control word for each converter port (line speed, interface mode, full duplex), the per-port reset-release bits, a link-polarity word and two switch override words. It presents every stored field as a registered output so that the converter datapath can use it directly.

All configuration registers are write-protected. A guard register at offset 0x000 accepts a fixed four-word key. Once the key has been written, configuration writes are accepted until software writes zero to the guard register. Writes made while the bank is locked are dropped without any effect. Reads are always permitted. Read data is registered and appears one cycle after the read strobe.

Top module: `conv_regbank`

## Requirements
- R1: After synchronous reset every stored register and every field output is zero, and the bank is locked (bit 0 of the guard register at 0x000 reads 0).
- R2: While locked, a write to any configuration register is dropped, and the stored value and its outputs stay unchanged.
- R3: Four writes to 0x000 of the whole data words 0x000000A5, 0x00000001, 0x0000FFFE and 0x00000001, in that order, unlock the bank. Bit 0 of 0x000 then reads 1.
- R4: Once unlocked, the bank accepts any number of configuration writes until it is locked again.
- R5: Writing zero to 0x000 locks the bank, and later configuration writes are dropped.
- R6: A guard write that does not match the expected key restarts the sequence. If that write is 0x000000A5, it counts as the first key.
- R7: While locked, a write to any address other than 0x000 abandons a key sequence that is in progress.
- R8: The control word of port p is at 0x100 + 4*p. Bits [1:0] hold speed (0=10M, 1=100M, 2=1000M), bits [3:2] hold mode (0=MII, 1=RMII, 2=RGMII) and bit 8 holds full duplex. The other bits read zero. The fields drive conv_speed, conv_mode and conv_fulldup, at slice p.
- R9: In the reset-release word at 0x114, bit p high releases converter p (conv_run[p]=1) and bit p low holds it in reset. Only NUM_PORTS bits are stored.
- R10: The routing mode is stored in the low MODE_W bits of 0x008, the link polarity in the low LINK_W bits of 0x014, and the switch speed and duplex overrides in the low NUM_PORTS bits of 0x304 and 0x308. Each drives its output.
- R11: Writes to undecoded addresses are ignored, and reads of undecoded addresses return zero.
- R12: rd_data takes the addressed value on the clock edge where rd_en is high and holds it while rd_en is low.
- R13: Key words are compared over the full data width, so 0x000100A5 is not a key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |
| route_mode | output | MODE_W | Routing-mode word |
| conv_speed | output | 2*NUM_PORTS | Speed field per port |
| conv_mode | output | 2*NUM_PORTS | Interface mode field per port |
| conv_fulldup | output | NUM_PORTS | Full-duplex bit per port |
| conv_run | output | NUM_PORTS | Converter reset release per port |
| link_pol | output | LINK_W | Link-polarity word |
| sw_spd_ovr | output | NUM_PORTS | Switch speed override bits |
| sw_dup_ovr | output | NUM_PORTS | Switch duplex override bits |

## Verification
The bench targets the key sequencer's edges:
- A repeated first key. A design that dropped back to step zero here would stay locked after a valid tail.
- A wrong third key followed by the correct tail. A design that did not restart would unlock.
- A key word with a stray upper bit. A design that compared only the low half would unlock.
- A configuration write placed in the middle of the sequence. A design that ignored it would unlock.

Field masking on readback, zero reads of holes in the map, the read hold, relock and a second reset are also checked. A design that got these wrong would show stray high bits, non-zero data from a hole, or stale data.

// File: rtl/conv_regbank_pkg.sv
package conv_regbank_pkg;

  localparam logic [15:0] OFS_GUARD  = 16'h000;
  localparam logic [15:0] OFS_ROUTE  = 16'h008;
  localparam logic [15:0] OFS_LINK   = 16'h014;
  localparam logic [15:0] OFS_CONV0  = 16'h100;
  localparam logic [15:0] OFS_RUN    = 16'h114;
  localparam logic [15:0] OFS_SWSPD  = 16'h304;
  localparam logic [15:0] OFS_SWDUP  = 16'h308;

  localparam logic [31:0] KEY_A      = 32'h0000_00A5;
  localparam logic [31:0] KEY_B      = 32'h0000_0001;
  localparam logic [31:0] KEY_C      = 32'h0000_FFFE;
  localparam logic [31:0] KEY_D      = 32'h0000_0001;
  localparam logic [31:0] RELOCK_VAL = 32'h0000_0000;

  localparam int SPD_LSB  = 0;
  localparam int MODE_LSB = 2;
  localparam int DUP_BIT  = 8;

  typedef enum logic [1:0] {
    WANT_A = 2'd0,
    WANT_B = 2'd1,
    WANT_C = 2'd2,
    WANT_D = 2'd3
  } key_step_e;

endpackage

// File: rtl/conv_key_seq.sv
module conv_key_seq
  import conv_regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              guard_wr,
  input  logic              other_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);

  key_step_e         step_q;
  logic [DATA_W-1:0] want;
  logic              is_relock;
  logic              is_first;
  logic              is_match;

  always_comb begin
    case (step_q)
      WANT_A:  want = DATA_W'(KEY_A);
      WANT_B:  want = DATA_W'(KEY_B);
      WANT_C:  want = DATA_W'(KEY_C);
      default: want = DATA_W'(KEY_D);
    endcase
  end

  assign is_relock = (wdata == DATA_W'(RELOCK_VAL));
  assign is_first  = (wdata == DATA_W'(KEY_A));
  assign is_match  = (wdata == want);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q   <= WANT_A;
      unlocked <= 1'b0;
    end else if (guard_wr) begin
      if (is_relock) begin
        unlocked <= 1'b0;
        step_q   <= WANT_A;
      end else if (!unlocked) begin
        if (is_match) begin
          if (step_q == WANT_D) begin
            unlocked <= 1'b1;
            step_q   <= WANT_A;
          end else begin
            step_q <= key_step_e'(step_q + 2'd1);
          end
        end else if (is_first) begin
          step_q <= WANT_B;
        end else begin
          step_q <= WANT_A;
        end
      end
    end else if (other_wr && !unlocked) begin
      step_q <= WANT_A;
    end
  end

  // R5
  relock_chk: assert property (@(posedge clk) disable iff (rst)
    (guard_wr && wdata == DATA_W'(RELOCK_VAL)) |=> !unlocked);

  // R3
  unlock_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(guard_wr && wdata == DATA_W'(KEY_D)));

  // R6
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && guard_wr && wdata != DATA_W'(KEY_A) && wdata != DATA_W'(KEY_B)
     && wdata != DATA_W'(KEY_C)) |=> !unlocked);

endmodule

// File: rtl/conv_port_cfg.sv
module conv_port_cfg
  import conv_regbank_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [2*NUM_PORTS-1:0] speed,
  output logic [2*NUM_PORTS-1:0] mode,
  output logic [NUM_PORTS-1:0]   fulldup
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(OFS_CONV0 + 4 * p);
    logic [1:0] spd_q;
    logic [1:0] mode_q;
    logic       dup_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        spd_q  <= '0;
        mode_q <= '0;
        dup_q  <= 1'b0;
      end else if (cfg_we && addr == MY_ADDR) begin
        spd_q  <= wdata[SPD_LSB +: 2];
        mode_q <= wdata[MODE_LSB +: 2];
        dup_q  <= wdata[DUP_BIT];
      end
    end

    assign speed[2*p +: 2] = spd_q;
    assign mode[2*p +: 2]  = mode_q;
    assign fulldup[p]      = dup_q;
  end

endmodule

// File: rtl/conv_rd_mux.sv
module conv_rd_mux
  import conv_regbank_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int MODE_W    = 5,
  parameter int LINK_W    = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   unlocked,
  input  logic [MODE_W-1:0]      route,
  input  logic [LINK_W-1:0]      link,
  input  logic [NUM_PORTS-1:0]   run,
  input  logic [NUM_PORTS-1:0]   swspd,
  input  logic [NUM_PORTS-1:0]   swdup,
  input  logic [2*NUM_PORTS-1:0] speed,
  input  logic [2*NUM_PORTS-1:0] mode,
  input  logic [NUM_PORTS-1:0]   fulldup,
  output logic [DATA_W-1:0]      rd_data
);

  logic [DATA_W-1:0] conv_word;
  logic              conv_hit;
  logic [DATA_W-1:0] word;
  logic              hit;

  always_comb begin
    conv_word = '0;
    conv_hit  = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr == ADDR_W'(OFS_CONV0 + 4 * p)) begin
        conv_hit                  = 1'b1;
        conv_word[SPD_LSB +: 2]   = speed[2*p +: 2];
        conv_word[MODE_LSB +: 2]  = mode[2*p +: 2];
        conv_word[DUP_BIT]        = fulldup[p];
      end
    end
  end

  always_comb begin
    word = '0;
    hit  = 1'b1;
    if (addr == ADDR_W'(OFS_GUARD))      word[0] = unlocked;
    else if (addr == ADDR_W'(OFS_ROUTE)) word[MODE_W-1:0] = route;
    else if (addr == ADDR_W'(OFS_LINK))  word[LINK_W-1:0] = link;
    else if (addr == ADDR_W'(OFS_RUN))   word[NUM_PORTS-1:0] = run;
    else if (addr == ADDR_W'(OFS_SWSPD)) word[NUM_PORTS-1:0] = swspd;
    else if (addr == ADDR_W'(OFS_SWDUP)) word[NUM_PORTS-1:0] = swdup;
    else if (conv_hit)                   word = conv_word;
    else                                 hit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= word;
  end

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R11
  rdata_hole_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit) |=> (rd_data == '0));

endmodule

// File: rtl/conv_regbank.sv
module conv_regbank
  import conv_regbank_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int MODE_W    = 5,
  parameter int LINK_W    = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr_en,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   rd_en,
  output logic [DATA_W-1:0]      rd_data,
  output logic [MODE_W-1:0]      route_mode,
  output logic [2*NUM_PORTS-1:0] conv_speed,
  output logic [2*NUM_PORTS-1:0] conv_mode,
  output logic [NUM_PORTS-1:0]   conv_fulldup,
  output logic [NUM_PORTS-1:0]   conv_run,
  output logic [LINK_W-1:0]      link_pol,
  output logic [NUM_PORTS-1:0]   sw_spd_ovr,
  output logic [NUM_PORTS-1:0]   sw_dup_ovr
);

  logic sel_guard;
  logic guard_wr;
  logic other_wr;
  logic cfg_we;
  logic unlocked;

  assign sel_guard = (addr == ADDR_W'(OFS_GUARD));
  assign guard_wr  = wr_en && sel_guard;
  assign other_wr  = wr_en && !sel_guard;
  assign cfg_we    = other_wr && unlocked;

  conv_key_seq #(.DATA_W(DATA_W)) u_key (
    .clk      (clk),
    .rst      (rst),
    .guard_wr (guard_wr),
    .other_wr (other_wr),
    .wdata    (wr_data),
    .unlocked (unlocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      route_mode <= '0;
      link_pol   <= '0;
      conv_run   <= '0;
      sw_spd_ovr <= '0;
      sw_dup_ovr <= '0;
    end else if (cfg_we) begin
      if (addr == ADDR_W'(OFS_ROUTE)) route_mode <= wr_data[MODE_W-1:0];
      if (addr == ADDR_W'(OFS_LINK))  link_pol   <= wr_data[LINK_W-1:0];
      if (addr == ADDR_W'(OFS_RUN))   conv_run   <= wr_data[NUM_PORTS-1:0];
      if (addr == ADDR_W'(OFS_SWSPD)) sw_spd_ovr <= wr_data[NUM_PORTS-1:0];
      if (addr == ADDR_W'(OFS_SWDUP)) sw_dup_ovr <= wr_data[NUM_PORTS-1:0];
    end
  end

  conv_port_cfg #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_ports (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .addr    (addr),
    .wdata   (wr_data),
    .speed   (conv_speed),
    .mode    (conv_mode),
    .fulldup (conv_fulldup)
  );

  conv_rd_mux #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MODE_W    (MODE_W),
    .LINK_W    (LINK_W)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .unlocked (unlocked),
    .route    (route_mode),
    .link     (link_pol),
    .run      (conv_run),
    .swspd    (sw_spd_ovr),
    .swdup    (sw_dup_ovr),
    .speed    (conv_speed),
    .mode     (conv_mode),
    .fulldup  (conv_fulldup),
    .rd_data  (rd_data)
  );

  // R2
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> ($stable(route_mode) && $stable(link_pol) && $stable(conv_run)
                   && $stable(sw_spd_ovr) && $stable(sw_dup_ovr)
                   && $stable(conv_speed) && $stable(conv_mode)
                   && $stable(conv_fulldup)));

  // R11
  hole_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(12'h200)) |=> ($stable(route_mode) && $stable(conv_run)));

endmodule

// File: tb/conv_regbank_bench.sv
module conv_regbank_bench;

  localparam int NP = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [4:0]  route_mode;
  logic [9:0]  conv_speed;
  logic [9:0]  conv_mode;
  logic [4:0]  conv_fulldup;
  logic [4:0]  conv_run;
  logic [11:0] link_pol;
  logic [4:0]  sw_spd_ovr;
  logic [4:0]  sw_dup_ovr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  conv_regbank u_conv_regbank (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .route_mode   (route_mode),
    .conv_speed   (conv_speed),
    .conv_mode    (conv_mode),
    .conv_fulldup (conv_fulldup),
    .conv_run     (conv_run),
    .link_pol     (link_pol),
    .sw_spd_ovr   (sw_spd_ovr),
    .sw_dup_ovr   (sw_dup_ovr)
  );

  // entry: op(1 = read-check), address, data, expected, requirement number
  localparam int NV = 30;
  localparam logic [81:0] TAB [NV] = '{
    {2'd1, 12'h000, 32'h0,        32'h0,     4'd1},  // R1 locked at start
    {2'd0, 12'h008, 32'h1F,       32'h0,     4'd2},  // R2 dropped
    {2'd0, 12'h100, 32'hFFFFFFFF, 32'h0,     4'd2},
    {2'd1, 12'h008, 32'h0,        32'h0,     4'd2},
    {2'd1, 12'h100, 32'h0,        32'h0,     4'd2},
    {2'd0, 12'h000, 32'hA5,       32'h0,     4'd3},  // R3 key
    {2'd0, 12'h000, 32'h1,        32'h0,     4'd3},
    {2'd0, 12'h000, 32'hFFFE,     32'h0,     4'd3},
    {2'd0, 12'h000, 32'h1,        32'h0,     4'd3},
    {2'd1, 12'h000, 32'h0,        32'h1,     4'd3},
    {2'd0, 12'h008, 32'h13,       32'h0,     4'd4},  // R4 several writes
    {2'd0, 12'h100, 32'h106,      32'h0,     4'd4},
    {2'd0, 12'h104, 32'hFFFFFFFF, 32'h0,     4'd4},
    {2'd1, 12'h008, 32'h0,        32'h13,    4'd10}, // R10
    {2'd1, 12'h100, 32'h0,        32'h106,   4'd8},  // R8
    {2'd1, 12'h104, 32'h0,        32'h10F,   4'd8},
    {2'd0, 12'h114, 32'hFFFFFFFF, 32'h0,     4'd9},  // R9
    {2'd1, 12'h114, 32'h0,        32'h1F,    4'd9},
    {2'd0, 12'h014, 32'hFFFFFFFF, 32'h0,     4'd10},
    {2'd1, 12'h014, 32'h0,        32'hFFF,   4'd10},
    {2'd0, 12'h304, 32'hFF,       32'h0,     4'd10},
    {2'd1, 12'h304, 32'h0,        32'h1F,    4'd10},
    {2'd0, 12'h308, 32'h15,       32'h0,     4'd10},
    {2'd1, 12'h308, 32'h0,        32'h15,    4'd10},
    {2'd0, 12'h200, 32'h55,       32'h0,     4'd11}, // R11
    {2'd1, 12'h200, 32'h0,        32'h0,     4'd11},
    {2'd0, 12'h000, 32'h0,        32'h0,     4'd5},  // R5 relock
    {2'd1, 12'h000, 32'h0,        32'h0,     4'd5},
    {2'd0, 12'h008, 32'h1,        32'h0,     4'd5},
    {2'd1, 12'h008, 32'h0,        32'h13,    4'd5}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic key(input logic [31:0] k0, k1, k2, k3);
    wr(12'h000, k0); wr(12'h000, k1); wr(12'h000, k2); wr(12'h000, k3);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset outputs
    check("R1 outputs", {route_mode, conv_run, conv_fulldup, sw_spd_ovr, sw_dup_ovr,
                         7'd0}, 32'h0);
    check("R1 wide", {conv_speed, conv_mode, link_pol}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (TAB[i][81:80] == 2'd0) begin
        wr(TAB[i][79:68], TAB[i][67:36]);
      end else begin
        rd(TAB[i][79:68], v);
        check($sformatf("R%0d table row %0d", TAB[i][3:0], i), v, TAB[i][35:4]);
      end
    end

    // R8 R9 R10 field outputs
    check("R8 port fields", {22'd0, conv_speed[3:0], conv_mode[3:0], conv_fulldup[1:0]},
          {22'd0, 4'b1110, 4'b1101, 2'b11});
    check("R9 run", {27'd0, conv_run}, 32'h1F);
    check("R10 outs", {3'd0, route_mode, link_pol, sw_spd_ovr, sw_dup_ovr},
          {3'd0, 5'h13, 12'hFFF, 5'h1F, 5'h15});

    // R6 repeated first key
    key(32'hA5, 32'hA5, 32'h1, 32'hFFFE);
    wr(12'h000, 32'h1);
    rd(12'h000, v);
    check("R6 repeated first key", v, 32'h1);
    wr(12'h000, 32'h0);

    // R6 broken sequence then tail
    key(32'hA5, 32'h1, 32'h2, 32'hFFFE);
    wr(12'h000, 32'h1);
    rd(12'h000, v);
    check("R6 broken key", v, 32'h0);

    // R7 interleaved configuration write
    wr(12'h000, 32'hA5); wr(12'h000, 32'h1);
    wr(12'h008, 32'h7);
    wr(12'h000, 32'hFFFE); wr(12'h000, 32'h1);
    rd(12'h000, v);
    check("R7 interleaved guard", v, 32'h0);
    rd(12'h008, v);
    check("R7 interleaved data", v, 32'h13);

    // R13 upper bit set in key
    key(32'h000100A5, 32'h1, 32'hFFFE, 32'h1);
    rd(12'h000, v);
    check("R13 wide compare", v, 32'h0);

    // R12 hold while rd_en low
    rd(12'h008, v);
    @(negedge clk);
    addr = 12'h114;
    repeat (3) @(negedge clk);
    check("R12 hold", rd_data, 32'h13);

    // R1 second reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(12'h114, v);
    check("R1 rerun", v, 32'h0);
    check("R1 rerun outs", {27'd0, route_mode}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

endmodule